// File: doc/BRIEF.md
# Event Timer Comparator Channel

One comparator channel of a high-precision event timer. The block sees a shared, free-running main counter from outside and compares it against its own comparator register. It raises an interrupt event when the two match. In one-shot mode the comparator is left untouched. In periodic mode the channel advances the comparator by a stored period after every match, so the channel goes on firing at a fixed interval without software help.

Software reaches the channel through a simple register write port and a combinational read port. The channel owns two 64-bit words: a configuration/capability word and the comparator word. The block drives three outputs. The first is a status-set pulse for the global status register, which lives outside. The second is an edge-type interrupt pulse. The third is a level-type interrupt line, which stays high until the outside status logic signals a clear. Capability bits are parameters: whether the channel can run periodically, and whether its comparator is 64 bits wide. A wide channel can be forced into 32-bit operation, in which case a wrap of the low counter half also counts as an event.

Top module: `evt_cmp_channel`

## Requirements
- R1: The configuration word decodes at byte address 0x100 + 0x20*CH_IDX and the comparator at 0x108 + 0x20*CH_IDX. Any other read address returns 0, and writes to other addresses change nothing. Configuration layout: bit1 level mode, bit2 interrupt enable, bit3 periodic, bit4 periodic capability (read-only), bit5 64-bit capability (read-only), bit6 value-set, bit8 force-32-bit. All other bits read 0.
- R2: After reset the writable configuration bits read 0. The comparator reads all ones over its width (64 or 32 bits), and all three outputs are 0.
- R3: While global enable is 1, a cycle in which the counter equals the comparator is an event. The exception is a cycle where the previous cycle had the same counter value and was also equal. One cycle after an event, sts_set is 1 for one cycle. In one-shot mode the comparator never changes except by a write.
- R4: With global enable at 0, no event occurs and no output rises.
- R5: In periodic mode every compare event adds the stored period to the comparator.
- R6: Writing the configuration word with bit6 set arms value-set, and bit6 then reads 1. The next comparator write loads only the compare target. The write after that loads only the period, and bit6 then reads 0.
- R7: A comparator write without value-set armed loads both the compare target and the period with the written value.
- R8: On a channel without periodic capability, bit3 writes are ignored, bit3 reads 0 and the comparator is never advanced.
- R9: Interrupt enable (bit2) gates irq_edge and irq_level but not sts_set.
- R10: In edge mode (bit1 = 0) with interrupts enabled, irq_edge is a one-cycle pulse one cycle after each event.
- R11: In level mode (bit1 = 1), irq_level stays 1 from the cycle after an event until the cycle after sts_clr, whatever further events occur. An event in the same cycle as sts_clr keeps it at 1.
- R12: On a 64-bit channel with bit8 = 1, only the low 32 bits of counter and comparator are compared. The low counter half stepping from 0xFFFFFFFF to 0 is also an event. With bit8 = 0 that step is not an event.
- R13: A channel without 64-bit capability always runs in 32-bit operation. Bit8 reads 0 there, and the comparator stores only the low 32 bits of a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable; matches only evaluated while 1 |
| main_cnt | input | 64 | Shared main counter value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 64 | Register read data (combinational) |
| sts_clr | input | 1 | Clear of the level interrupt from the status register |
| sts_set | output | 1 | One-cycle pulse per event, for the status register |
| irq_edge | output | 1 | Edge-mode interrupt pulse |
| irq_level | output | 1 | Level-mode interrupt line |

## Verification
A wrong comparator or period shows at the ports as an sts_set pulse on the wrong counter value. In periodic mode the error turns into a drifting firing pattern by the second or third event, and the comparator readback after a run shows it directly. A stuck value-set sequencer shows on the very next comparator readback, because bit6 fails to clear or the target holds the period. A broken level latch or wrap detector shows one cycle after the stimulus on irq_level or sts_set.

// File: rtl/evt_tmr_pkg.sv
// Package: shared field positions and types for the event timer channel.
// Assumes 64-bit register words; positions are those software decodes.
package evt_tmr_pkg;
    localparam int WORD_W      = 64;
    localparam int BIT_LVL     = 1;
    localparam int BIT_IEN     = 2;
    localparam int BIT_PER     = 3;
    localparam int BIT_CAP_PER = 4;
    localparam int BIT_CAP_64  = 5;
    localparam int BIT_VSET    = 6;
    localparam int BIT_M32     = 8;

    // Writable configuration state of one channel.
    typedef struct packed {
        logic m32;      // force 32-bit operation
        logic periodic; // periodic mode
        logic ien;      // interrupt enable
        logic lvl;      // level mode
    } chan_cfg_t;

    // Clear the upper half of a word.
    function automatic logic [WORD_W-1:0] low_half(input logic [WORD_W-1:0] v);
        return {{(WORD_W/2){1'b0}}, v[WORD_W/2-1:0]};
    endfunction
endpackage

// File: rtl/evt_cfg_regs.sv
// Configuration register of one channel.
// Holds level, enable, periodic and force-32 bits; masks bits the channel
// lacks the capability for; raises a one-cycle arm pulse for value-set.
// Assumes a write strobe already decoded for this word.
module evt_cfg_regs
    import evt_tmr_pkg::*;
#(
    parameter bit PERIODIC_CAP = 1'b1,
    parameter bit WIDE_CAP     = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_we,
    input  logic      wb_lvl,
    input  logic      wb_ien,
    input  logic      wb_per,
    input  logic      wb_vset,
    input  logic      wb_m32,
    output chan_cfg_t cfg_o,
    output logic      vs_arm_o
);
    chan_cfg_t cfg_q;

    // Capture writable bits, dropping those without capability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.lvl      <= wb_lvl;
            cfg_q.ien      <= wb_ien;
            cfg_q.periodic <= wb_per & PERIODIC_CAP;
            cfg_q.m32      <= wb_m32 & WIDE_CAP;
        end
    end

    assign cfg_o    = cfg_q;
    assign vs_arm_o = cfg_we & wb_vset;
endmodule

// File: rtl/evt_cmp_store.sv
// Comparator and period storage of one channel.
// A plain comparator write sets target and period; with value-set armed,
// the first write sets the target and the second the period, after which
// value-set clears. In periodic mode a compare event adds the period.
// Assumes arm pulse and comparator write never coincide.
module evt_cmp_store
    import evt_tmr_pkg::*;
#(
    parameter bit WIDE_CAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              vs_arm,
    input  logic              periodic,
    input  logic              mode32,
    input  logic              fire,
    output logic [WORD_W-1:0] cmp_o,
    output logic              vs_o
);
    localparam logic [WORD_W-1:0] CMP_RST =
        WIDE_CAP ? {WORD_W{1'b1}} : {{(WORD_W/2){1'b0}}, {(WORD_W/2){1'b1}}};

    logic [WORD_W-1:0] cmp_q, per_q, wval, next_cmp, sum_full;
    logic              vs_q, phase_q;

    assign wval     = WIDE_CAP ? wdata : low_half(wdata);
    assign sum_full = cmp_q + per_q;
    assign next_cmp = mode32 ? low_half(sum_full) : sum_full;

    // Comparator target and period update, write wins over reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= CMP_RST;
            per_q <= '0;
        end else if (cmp_we) begin
            if (vs_q && phase_q) begin
                per_q <= wval;
            end else if (vs_q) begin
                cmp_q <= wval;
            end else begin
                cmp_q <= wval;
                per_q <= wval;
            end
        end else if (fire && periodic) begin
            cmp_q <= next_cmp;
        end
    end

    // Value-set sequencer: arm, then target write, then period write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q    <= 1'b0;
            phase_q <= 1'b0;
        end else if (vs_arm) begin
            vs_q    <= 1'b1;
            phase_q <= 1'b0;
        end else if (cmp_we && vs_q) begin
            vs_q    <= ~phase_q;
            phase_q <= ~phase_q;
        end
    end

    assign cmp_o = cmp_q;
    assign vs_o  = vs_q;

    p_cmp_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && !cmp_we) |=> $stable(cmp_q));
    p_vs_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && vs_q && phase_q && !vs_arm) |=> !vs_q);
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && periodic && !cmp_we && !mode32) |=> (cmp_q == $past(cmp_q + per_q)));
endmodule

// File: rtl/evt_match.sv
// Match detector of one channel.
// Signals a compare event on counter/comparator equality, suppressed when
// the counter has not moved since an equal cycle; in 32-bit operation it
// also signals the wrap of the low counter half. Assumes glb_en gating.
module evt_match
    import evt_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic [WORD_W-1:0] cnt,
    input  logic [WORD_W-1:0] cmp,
    input  logic              mode32,
    output logic              fire_o,
    output logic              ev_o
);
    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] prev_q;
    logic              eq, eq_q, prev_ok_q, hold, wrap;

    assign eq     = mode32 ? (cnt[HALF-1:0] == cmp[HALF-1:0]) : (cnt == cmp);
    assign hold   = eq_q && (cnt == prev_q);
    assign fire_o = glb_en && eq && !hold;
    assign wrap   = glb_en && mode32 && prev_ok_q
                    && (prev_q[HALF-1:0] == {HALF{1'b1}})
                    && (cnt[HALF-1:0] == '0);
    assign ev_o   = fire_o || wrap;

    // History of counter and equality for hold and wrap detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            eq_q      <= 1'b0;
            prev_ok_q <= 1'b0;
        end else begin
            prev_q    <= cnt;
            eq_q      <= eq && glb_en;
            prev_ok_q <= 1'b1;
        end
    end
endmodule

// File: rtl/evt_irq_out.sv
// Output stage of one channel.
// Registers the status-set pulse, the edge interrupt pulse and the level
// latch; the latch holds until a clear, a new event wins over the clear.
module evt_irq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic int_en,
    input  logic lvl_mode,
    input  logic sts_clr,
    output logic sts_set_o,
    output logic irq_edge_o,
    output logic irq_level_o
);
    logic sts_q, edge_q, lvl_q;

    // Pulse outputs follow the event by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            sts_q  <= ev;
            edge_q <= ev && int_en && !lvl_mode;
        end
    end

    // Level latch: set by event, cleared by status clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else if (ev && lvl_mode) begin
            lvl_q <= 1'b1;
        end else if (sts_clr) begin
            lvl_q <= 1'b0;
        end
    end

    assign sts_set_o   = sts_q;
    assign irq_edge_o  = edge_q;
    assign irq_level_o = lvl_q && int_en;

    p_sts_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> sts_q);
    p_edge_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && int_en && !lvl_mode) |=> edge_q);
    p_level_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q && !sts_clr) |=> lvl_q);
endmodule

// File: rtl/evt_cmp_channel.sv
// Top of one event timer comparator channel.
// Decodes the channel's two register words, assembles readback, and wires
// configuration, comparator storage, match detection and outputs.
// Assumes the main counter and status register live outside.
module evt_cmp_channel
    import evt_tmr_pkg::*;
#(
    parameter int CH_IDX       = 0,
    parameter int ADDR_W       = 12,
    parameter bit PERIODIC_CAP = 1'b1,
    parameter bit WIDE_CAP     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic [63:0]       main_cnt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data,
    input  logic              sts_clr,
    output logic              sts_set,
    output logic              irq_edge,
    output logic              irq_level
);
    localparam int                CFG_OFF_I = 256 + 32 * CH_IDX;
    localparam int                CMP_OFF_I = CFG_OFF_I + 8;
    localparam logic [ADDR_W-1:0] CFG_OFF   = CFG_OFF_I[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] CMP_OFF   = CMP_OFF_I[ADDR_W-1:0];

    chan_cfg_t         cfg;
    logic              cfg_we, cmp_we, vs_arm, vs_flag, mode32, fire, ev;
    logic [WORD_W-1:0] cmp_val, cfg_word;

    assign cfg_we = wr_en && (wr_addr == CFG_OFF);
    assign cmp_we = wr_en && (wr_addr == CMP_OFF);
    assign mode32 = !WIDE_CAP || cfg.m32;

    evt_cfg_regs #(.PERIODIC_CAP(PERIODIC_CAP), .WIDE_CAP(WIDE_CAP)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .wb_lvl  (wr_data[BIT_LVL]),
        .wb_ien  (wr_data[BIT_IEN]),
        .wb_per  (wr_data[BIT_PER]),
        .wb_vset (wr_data[BIT_VSET]),
        .wb_m32  (wr_data[BIT_M32]),
        .cfg_o   (cfg),
        .vs_arm_o(vs_arm)
    );

    evt_cmp_store #(.WIDE_CAP(WIDE_CAP)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_we  (cmp_we),
        .wdata   (wr_data),
        .vs_arm  (vs_arm),
        .periodic(cfg.periodic),
        .mode32  (mode32),
        .fire    (fire),
        .cmp_o   (cmp_val),
        .vs_o    (vs_flag)
    );

    evt_match u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .glb_en(glb_en),
        .cnt   (main_cnt),
        .cmp   (cmp_val),
        .mode32(mode32),
        .fire_o(fire),
        .ev_o  (ev)
    );

    evt_irq_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .int_en     (cfg.ien),
        .lvl_mode   (cfg.lvl),
        .sts_clr    (sts_clr),
        .sts_set_o  (sts_set),
        .irq_edge_o (irq_edge),
        .irq_level_o(irq_level)
    );

    // Assemble the configuration/capability readback word.
    always_comb begin
        cfg_word              = '0;
        cfg_word[BIT_LVL]     = cfg.lvl;
        cfg_word[BIT_IEN]     = cfg.ien;
        cfg_word[BIT_PER]     = cfg.periodic;
        cfg_word[BIT_CAP_PER] = PERIODIC_CAP;
        cfg_word[BIT_CAP_64]  = WIDE_CAP;
        cfg_word[BIT_VSET]    = vs_flag;
        cfg_word[BIT_M32]     = cfg.m32;
    end

    // Read multiplexer over the channel's two words.
    always_comb begin
        if (rd_addr == CFG_OFF)      rd_data = cfg_word;
        else if (rd_addr == CMP_OFF) rd_data = cmp_val;
        else                         rd_data = '0;
    end

    p_quiet_halted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !sts_set);
    p_edge_with_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_edge |-> sts_set);
endmodule

// File: tb/sim_evt_cmp_channel.sv
module sim_evt_cmp_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic [63:0] main_cnt = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic        sts_clr = 1'b0;
    logic [63:0] rd0, rd1;
    logic        sts0, edg0, lvl0, sts1, edg1, lvl1;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    localparam logic [11:0] C0_CFG = 12'h160, C0_CMP = 12'h168;
    localparam logic [11:0] C1_CFG = 12'h100, C1_CMP = 12'h108;

    always #2 clk = ~clk;

    evt_cmp_channel #(.CH_IDX(3)) u0 (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .main_cnt(main_cnt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd0), .sts_clr(sts_clr), .sts_set(sts0), .irq_edge(edg0),
        .irq_level(lvl0));

    evt_cmp_channel #(.CH_IDX(0), .PERIODIC_CAP(1'b0), .WIDE_CAP(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .main_cnt(main_cnt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd1), .sts_clr(sts_clr), .sts_set(sts1), .irq_edge(edg1),
        .irq_level(lvl1));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected comparator after a periodic step, from R5/R12.
    function automatic logic [63:0] next_target(input logic [63:0] t, input logic [63:0] p);
        return t + p;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] v0, output logic [63:0] v1);
        rd_addr = a;
        #1;
        v0 = rd0; v1 = rd1;
    endtask

    // Set counter, advance one clock, sample away from the edge.
    task automatic step(input logic [63:0] c);
        main_cnt = c;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b, nxt, per, tgt, c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R1 reset readback
        rd(C0_CFG, a, b);
        check("R2 u0 cfg caps", a, 64'h30);
        check("R2 u1 cfg", b, 64'h0);
        rd(C0_CMP, a, b);
        check("R2 u0 cmp", a, '1);
        rd(C1_CMP, a, b);
        check("R2 u1 cmp", b, 64'hFFFF_FFFF);
        check("R2 outputs", {61'b0, sts0, edg0, lvl0}, 64'h0);
        rd(12'h170, a, b);
        check("R1 unmapped read", a, 64'h0);

        // R3 one-shot edge, R10
        wr(C0_CFG, 64'h4);
        wr(C0_CMP, 64'd100);
        rd(C1_CFG, a, b);
        check("R1 u1 untouched by u0 write", b, 64'h0);
        main_cnt = 64'd96;
        glb_en = 1'b1;
        for (int v = 97; v <= 103; v++) begin
            step(64'(v));
            check("R3 one-shot sts_set", 64'(sts0), 64'(v == 100));
            check("R10 edge pulse", 64'(edg0), 64'(v == 100));
        end
        rd(C0_CMP, a, b);
        check("R3 comparator unchanged", a, 64'd100);
        step(64'd100);
        check("R3 event on re-entry", 64'(sts0), 64'd1);
        step(64'd100);
        check("R3 held counter no repeat", 64'(sts0), 64'd0);

        // R4 disabled
        glb_en = 1'b0;
        step(64'd99);
        step(64'd100);
        check("R4 no event while disabled", 64'(sts0), 64'd0);

        // R9 interrupt enable off
        wr(C0_CFG, 64'h0);
        step(64'd99);
        glb_en = 1'b1;
        step(64'd100);
        check("R9 sts_set without enable", 64'(sts0), 64'd1);
        check("R9 irq_edge gated", 64'(edg0), 64'd0);

        // R11 level mode
        glb_en = 1'b0;
        wr(C0_CFG, 64'h6);
        wr(C0_CMP, 64'd300);
        step(64'd298);
        glb_en = 1'b1;
        step(64'd299);
        check("R11 level low before", 64'(lvl0), 64'd0);
        step(64'd300);
        check("R11 level set", 64'(lvl0), 64'd1);
        check("R11 no edge in level mode", 64'(edg0), 64'd0);
        step(64'd301);
        step(64'd302);
        check("R11 level held", 64'(lvl0), 64'd1);
        sts_clr = 1'b1;
        step(64'd303);
        sts_clr = 1'b0;
        check("R11 level cleared", 64'(lvl0), 64'd0);
        step(64'd299);
        sts_clr = 1'b1;
        step(64'd300);
        sts_clr = 1'b0;
        check("R11 event beats clear", 64'(lvl0), 64'd1);
        sts_clr = 1'b1;
        step(64'd301);
        sts_clr = 1'b0;

        // R7 plain write in periodic mode, R5 reload
        glb_en = 1'b0;
        wr(C0_CFG, 64'hC);
        wr(C0_CMP, 64'd50);
        step(64'd40);
        glb_en = 1'b1;
        nxt = 64'd50;
        for (int v = 41; v <= 160; v++) begin
            step(64'(v));
            check("R5 R7 periodic events", 64'(sts0), 64'(64'(v) == nxt));
            if (64'(v) == nxt) nxt = next_target(nxt, 64'd50);
        end
        rd(C0_CMP, a, b);
        check("R5 comparator advanced", a, 64'd200);

        // R6 value-set directed
        glb_en = 1'b0;
        wr(C0_CFG, 64'h4C);
        rd(C0_CFG, a, b);
        check("R6 vset reads 1", a, 64'h7C);
        wr(C0_CMP, 64'd1000);
        wr(C0_CMP, 64'd30);
        rd(C0_CFG, a, b);
        check("R6 vset cleared", a, 64'h3C);
        rd(C0_CMP, a, b);
        check("R6 target only", a, 64'd1000);
        step(64'd999);
        glb_en = 1'b1;
        step(64'd1000);
        check("R6 fires at target", 64'(sts0), 64'd1);
        rd(C0_CMP, a, b);
        check("R6 period separate", a, 64'd1030);

        // R5 R6 random periods via value-set
        c = 64'd5000;
        for (int k = 0; k < 20; k++) begin
            glb_en = 1'b0;
            tgt = c + 64'(1 + $urandom % 6);
            per = 64'(1 + $urandom % 7);
            wr(C0_CFG, 64'h4C);
            wr(C0_CMP, tgt);
            wr(C0_CMP, per);
            rd(C0_CFG, a, b);
            check("R6 random vset clears", a, 64'h3C);
            step(c);
            glb_en = 1'b1;
            nxt = tgt;
            for (int i = 0; i < 40; i++) begin
                c = c + 1;
                step(c);
                check("R5 random periodic sts", 64'(sts0), 64'(c == nxt));
                check("R10 random edge", 64'(edg0), 64'(c == nxt));
                if (c == nxt) nxt = next_target(nxt, per);
            end
            rd(C0_CMP, a, b);
            check("R5 random comparator", a, nxt);
            c = c + 100;
        end

        // R12 forced 32-bit on wide channel
        glb_en = 1'b0;
        wr(C0_CFG, 64'h104);
        wr(C0_CMP, 64'h1_0000_0010);
        rd(C0_CFG, a, b);
        check("R12 bit8 reads 1", a, 64'h134);
        step(64'h5_0000_000F);
        glb_en = 1'b1;
        step(64'h5_0000_0010);
        check("R12 low-half match", 64'(sts0), 64'd1);
        step(64'h2_FFFF_FFFF);
        step(64'h3_0000_0000);
        check("R12 wrap event", 64'(sts0), 64'd1);
        wr(C0_CFG, 64'h4);
        step(64'h3_FFFF_FFFF);
        step(64'h4_0000_0000);
        check("R12 no wrap event in 64-bit", 64'(sts0), 64'd0);
        step(64'h5_0000_0010);
        check("R12 full-width compare", 64'(sts0), 64'd0);

        // R8 R13 narrow, non-periodic channel
        glb_en = 1'b0;
        wr(C1_CFG, 64'h10C);
        rd(C1_CFG, a, b);
        check("R8 R13 u1 cfg readback", b, 64'h4);
        wr(C1_CMP, 64'hABCD_0000_0000_0123);
        rd(C1_CMP, a, b);
        check("R13 narrow store", b, 64'h123);
        step(64'h7_0000_0122);
        glb_en = 1'b1;
        step(64'h7_0000_0123);
        check("R13 low-half match", 64'(sts1), 64'd1);
        check("R9 u1 edge enabled", 64'(edg1), 64'd1);
        step(64'h7_0000_0124);
        rd(C1_CMP, a, b);
        check("R8 no periodic advance", b, 64'h123);
        step(64'hFFFF_FFFF);
        step(64'h1_0000_0000);
        check("R13 wrap always on", 64'(sts1), 64'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule